// File: doc/BRIEF.md
# Programmable DRAM Refresh Pacer

The refresh pacer issues periodic refresh requests to an external DRAM controller. It is set up through one software-visible control word with three parts:

- an enable bit;
- a rate field that gives the spacing between requests, in units of four clocks;
- a row field that names the next row to refresh.

While the pacer is enabled, a prescaler divides the clock by four. An interval counter counts the divided ticks. When the programmed number of units has elapsed, the pacer raises a request and presents the current row. The request stays up until the controller acknowledges it. On that acknowledge the hardware increments the row field inside the control word and starts the next interval.

Software can read the control word at any time and sees the live row. A write replaces all three fields and restarts the timing. Clearing the enable bit by a write withdraws a pending request and keeps the timers parked at zero.

Top module: `refresh_pacer`

## Requirements
- R1: After reset the control word reads 0x0000 and no request is raised.
- R2: A write loads the whole word. Bit 15 is the enable, bits 14:9 are the rate, and bits 8:0 are the row. The next cycle's read returns the written value, and the row output equals bits 8:0.
- R3: With the enable set and a rate r in 1..63, the request rises exactly 4·r clock cycles after the cycle in which the write was sampled.
- R4: A rate field of 0 selects 64 units, which gives 256 clock cycles between the restart and the request.
- R5: A raised request stays high, with the row held, for as long as no acknowledge or write arrives.
- R6: An acknowledge while the request is high does three things. It drops the request, it adds one to the row (both on the output and in the read word), and it restarts the interval so that the next request rises 4·units cycles after the acknowledge cycle.
- R7: The row increments from 511 to 0.
- R8: A write that clears the enable bit drops any pending request, and no request is raised while the enable stays clear.
- R9: A write while a request is pending drops the request and restarts the full interval with the newly written fields.
- R10: An acknowledge while no request is raised is ignored. It leaves the row, the read word and the timing of the next request unchanged.
- R11: When a write and an acknowledge arrive in the same cycle, the write wins. The row takes the written value with no increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Control word write strobe |
| wrData | input | 16 | Control word write value |
| rdData | output | 16 | Live control word (enable, rate, current row) |
| refReq | output | 1 | Refresh request, held until acknowledged |
| refAck | input | 1 | Refresh acknowledge from the DRAM controller |
| refRow | output | 9 | Row address to refresh |

## Verification
The hardest case to reach from the ports is a clash between a software write and the hardware's own row update. That clash happens when a write lands in the same cycle as an acknowledge of a pending request. The stimulus gets there by first waiting until the request is actually raised, then driving the write strobe and the acknowledge on one edge. It then checks that the written row survives and that the next request is timed from that write. Rate 0 and row 511 are reached by programming them directly, and the exact request time is compared against a cycle stamp taken at each restart.

// File: rtl/refresh_pacer_pkg.sv
package refresh_pacer_pkg;

  // Strobes issued by the control path to the datapath each cycle.
  typedef struct packed {
    logic loadWord;    // replace the whole control word from the write port
    logic advanceRow;  // a refresh was acknowledged: step the row field
  } paceStrobe_t;

  typedef enum logic [1:0] {
    PS_OFF   = 2'd0,   // disabled, timers parked at zero
    PS_COUNT = 2'd1,   // counting units toward the next request
    PS_WAIT  = 2'd2    // request raised, waiting for acknowledge
  } paceState_t;

endpackage

// File: rtl/refresh_pacer_dp.sv
module refresh_pacer_dp
  import refresh_pacer_pkg::*;
#(
  parameter int RATE_W = 6,
  parameter int ROW_W  = 9
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  paceStrobe_t               strobe,
  input  logic [RATE_W+ROW_W:0]     wrData,
  output logic [RATE_W+ROW_W:0]     wordOut,
  output logic                      newEnable,
  output logic [RATE_W-1:0]         rate,
  output logic [ROW_W-1:0]          row
);

  localparam int WORD_W   = 1 + RATE_W + ROW_W;
  localparam int EN_BIT   = WORD_W - 1;
  localparam int RATE_LSB = ROW_W;

  logic              enReg;
  logic [RATE_W-1:0] rateReg;
  logic [ROW_W-1:0]  rowReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      rateReg <= '0;
      rowReg  <= '0;
    end else if (strobe.loadWord) begin
      enReg   <= wrData[EN_BIT];
      rateReg <= wrData[RATE_LSB +: RATE_W];
      rowReg  <= wrData[ROW_W-1:0];
    end else if (strobe.advanceRow) begin
      rowReg  <= rowReg + ROW_W'(1);
    end
  end

  // Enable as it will stand after this edge; the control path uses it on writes.
  assign newEnable = strobe.loadWord ? wrData[EN_BIT] : enReg;
  assign rate      = rateReg;
  assign row       = rowReg;
  assign wordOut   = {enReg, rateReg, rowReg};

endmodule

// File: rtl/refresh_pacer_ctrl.sv
module refresh_pacer_ctrl
  import refresh_pacer_pkg::*;
#(
  parameter int RATE_W   = 6,
  parameter int PRESCALE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              newEnable,
  input  logic              refAck,
  input  logic [RATE_W-1:0] rate,
  output logic              refReq,
  output paceStrobe_t       strobe
);

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  paceState_t        state, stateNext;
  logic [RATE_W-1:0] unitCnt;
  logic [RATE_W-1:0] lastUnit;
  logic              tick;
  logic              clearCounts;
  logic              handshake;

  // rate - 1 wraps a zero rate to all ones, so zero selects the longest interval.
  assign lastUnit    = rate - RATE_W'(1);
  assign handshake   = (state == PS_WAIT) && refAck;
  assign clearCounts = wrEn || handshake;

  generate
    if (PRESCALE > 1) begin : g_prescale
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          preCnt <= '0;
        else if (clearCounts || state != PS_COUNT)
          preCnt <= '0;
        else if (preCnt == PRE_W'(PRESCALE - 1))
          preCnt <= '0;
        else
          preCnt <= preCnt + PRE_W'(1);
      end
      assign tick = (state == PS_COUNT) && (preCnt == PRE_W'(PRESCALE - 1));
    end else begin : g_noprescale
      assign tick = (state == PS_COUNT);
    end
  endgenerate

  always_comb begin
    stateNext = state;
    if (wrEn) begin
      stateNext = newEnable ? PS_COUNT : PS_OFF;
    end else begin
      case (state)
        PS_COUNT: if (tick && unitCnt == lastUnit) stateNext = PS_WAIT;
        PS_WAIT:  if (refAck) stateNext = PS_COUNT;
        default:  stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= PS_OFF;
      unitCnt <= '0;
    end else begin
      state <= stateNext;
      if (clearCounts || state != PS_COUNT)
        unitCnt <= '0;
      else if (tick)
        unitCnt <= (unitCnt == lastUnit) ? '0 : unitCnt + RATE_W'(1);
    end
  end

  assign refReq            = (state == PS_WAIT);
  assign strobe.loadWord   = wrEn;
  assign strobe.advanceRow = handshake && !wrEn;

endmodule

// File: rtl/refresh_pacer.sv
module refresh_pacer
  import refresh_pacer_pkg::*;
#(
  parameter int RATE_W   = 6,
  parameter int ROW_W    = 9,
  parameter int PRESCALE = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [RATE_W+ROW_W:0] wrData,
  output logic [RATE_W+ROW_W:0] rdData,
  output logic                  refReq,
  input  logic                  refAck,
  output logic [ROW_W-1:0]      refRow
);

  paceStrobe_t       strobe;
  logic              newEnable;
  logic [RATE_W-1:0] rate;

  refresh_pacer_ctrl #(
    .RATE_W  (RATE_W),
    .PRESCALE(PRESCALE)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .newEnable(newEnable),
    .refAck   (refAck),
    .rate     (rate),
    .refReq   (refReq),
    .strobe   (strobe)
  );

  refresh_pacer_dp #(
    .RATE_W(RATE_W),
    .ROW_W (ROW_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .wordOut  (rdData),
    .newEnable(newEnable),
    .rate     (rate),
    .row      (refRow)
  );

endmodule

// File: rtl/refresh_pacer_chk.sv
module refresh_pacer_chk #(
  parameter int RATE_W   = 6,
  parameter int ROW_W    = 9,
  parameter int PRESCALE = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [RATE_W+ROW_W:0] wrData,
  input logic [RATE_W+ROW_W:0] rdData,
  input logic                  refReq,
  input logic                  refAck,
  input logic [ROW_W-1:0]      refRow
);

  localparam int WORD_W = 1 + RATE_W + ROW_W;

  // Cycles since the last restart (write or acknowledged request), saturating.
  logic [31:0] gapCnt;
  logic [31:0] expGap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      gapCnt <= '0;
    else if (wrEn || (refReq && refAck))
      gapCnt <= '0;
    else if (gapCnt != '1)
      gapCnt <= gapCnt + 32'd1;
  end

  always_comb begin
    if (rdData[ROW_W +: RATE_W] == '0)
      expGap = 32'(PRESCALE) * (32'd1 << RATE_W);
    else
      expGap = 32'(PRESCALE) * 32'(rdData[ROW_W +: RATE_W]);
  end

  // R3 / R4: request rises exactly PRESCALE*units cycles after a restart
  a_r3_interval: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refReq) |-> gapCnt == expGap);

  // R2: written word is read back on the next cycle
  a_r2_load: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData == $past(wrData));

  // R5: an unanswered request stays up with the row held
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && !refAck && !wrEn) |=> (refReq && $stable(refRow)));

  // R6 / R7: acknowledge drops the request and steps the row with wrap
  a_r6_advance: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && refAck && !wrEn) |=> (!refReq && refRow == $past(refRow) + ROW_W'(1)));

  // R8: no request while the enable bit is clear
  a_r8_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[WORD_W-1] |-> !refReq);

  // R9: a write always leaves the request low on the following cycle
  a_r9_restart: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !refReq);

  // R10: stray acknowledge has no effect on the row
  a_r10_stray_ack: assert property (@(posedge clk) disable iff (!rstN)
    (!refReq && refAck && !wrEn) |=> $stable(refRow));

  // R11: write beats acknowledge
  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && refAck) |=> refRow == $past(wrData[ROW_W-1:0]));

endmodule

bind refresh_pacer refresh_pacer_chk #(
  .RATE_W  (RATE_W),
  .ROW_W   (ROW_W),
  .PRESCALE(PRESCALE)
) uPacerChk (
  .clk   (clk),
  .rstN  (rstN),
  .wrEn  (wrEn),
  .wrData(wrData),
  .rdData(rdData),
  .refReq(refReq),
  .refAck(refAck),
  .refRow(refRow)
);

// File: tb/refresh_pacer_test.sv
module refresh_pacer_test;

  localparam int UNIT = 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [15:0] wrData;
  logic [15:0] rdData;
  logic        refReq;
  logic        refAck;
  logic [8:0]  refRow;

  always #5 clk = ~clk;

  refresh_pacer uut (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrData(wrData),
    .rdData(rdData),
    .refReq(refReq),
    .refAck(refAck),
    .refRow(refRow)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nCmp = 0;
  int nBad = 0;
  logic [15:0] shadow = 16'h0000;

  typedef struct {
    int    when;
    int    row;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  task automatic check(string tag, int act, int exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  function automatic int units(logic [15:0] w);
    return (w[14:9] == 6'd0) ? 64 : int'(w[14:9]);
  endfunction

  // Driver: write a word (optionally with a simultaneous ack) and queue the expected request.
  task automatic writeWord(logic [15:0] w, logic withAck, string tag);
    @(negedge clk);
    wrData = w;
    wrEn   = 1'b1;
    refAck = withAck;
    @(negedge clk);
    wrEn   = 1'b0;
    refAck = 1'b0;
    shadow = w;
    expQ.delete();
    if (w[15]) expQ.push_back('{cyc + UNIT * units(w), int'(w[8:0]), tag});
  endtask

  // Driver: one-cycle acknowledge; queue the next request only if one was pending.
  task automatic ackNow(string tag);
    logic wasReq;
    @(negedge clk);
    refAck = 1'b1;
    wasReq = refReq;
    @(negedge clk);
    refAck = 1'b0;
    if (wasReq) begin
      shadow[8:0] = shadow[8:0] + 9'd1;
      expQ.push_back('{cyc + UNIT * units(shadow), int'(shadow[8:0]), tag});
    end
  endtask

  task automatic waitReq(string tag, int limit);
    int n = 0;
    while (!refReq && n < limit) begin
      @(negedge clk);
      n++;
    end
    if (!refReq) begin
      nCmp++;
      nBad++;
      $display("FAIL %s: request missing, actual low expected high", tag);
    end
  endtask

  // Monitor: compare each rising request against the scoreboard queue.
  logic prevReq = 1'b0;
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      if (refReq && !prevReq) begin
        if (expQ.size() == 0) begin
          nCmp++;
          nBad++;
          $display("FAIL R8 unexpected request: actual row %0d at cycle %0d expected none", refRow, cyc);
        end else begin
          expItem_t item;
          item = expQ.pop_front();
          check({item.tag, " request cycle"}, cyc, item.when);
          check({item.tag, " request row"}, int'(refRow), item.row);
        end
      end
      prevReq = refReq;
    end
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nCmp++;
    nBad++;
    $display("FAIL R3 watchdog: actual still running expected done");
    finishRun();
  end

  initial begin
    rstN   = 1'b0;
    wrEn   = 1'b0;
    wrData = 16'h0000;
    refAck = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 read word", int'(rdData), 0);
    check("R1 request", int'(refReq), 0);

    // R2, R3, R5, R6: rate 2, row 5
    writeWord(16'h8000 | (16'd2 << 9) | 16'd5, 1'b0, "R3");
    check("R2 read word", int'(rdData), int'(16'h8405));
    check("R2 row out", int'(refRow), 5);
    waitReq("R3", 50);
    repeat (10) @(negedge clk);
    check("R5 request held", int'(refReq), 1);
    check("R5 row held", int'(refRow), 5);
    ackNow("R6");
    check("R6 request dropped", int'(refReq), 0);
    check("R6 row stepped", int'(refRow), 6);
    check("R6 read word row", int'(rdData), int'(16'h8406));
    waitReq("R6", 50);

    // R7: row wrap at rate 1
    writeWord(16'h8000 | (16'd1 << 9) | 16'h01FF, 1'b0, "R3");
    waitReq("R7", 50);
    ackNow("R7");
    check("R7 row wrapped", int'(refRow), 0);
    waitReq("R7", 50);

    // R4: rate 0 means 64 units
    writeWord(16'h8000 | 16'd16, 1'b0, "R4");
    waitReq("R4", 400);

    // R10: stray acknowledge well before the request
    writeWord(16'h8000 | (16'd63 << 9) | 16'd40, 1'b0, "R10");
    repeat (10) @(negedge clk);
    ackNow("R10");
    check("R10 row unchanged", int'(refRow), 40);
    check("R10 word unchanged", int'(rdData), int'(16'h8000 | (16'd63 << 9) | 16'd40));
    waitReq("R10", 400);

    // R9: write while request pending restarts with new fields
    writeWord(16'h8000 | (16'd3 << 9) | 16'd20, 1'b0, "R9");
    check("R9 request dropped", int'(refReq), 0);
    check("R9 row loaded", int'(refRow), 20);
    waitReq("R9", 50);

    // R11: write and ack in the same cycle
    writeWord(16'h8000 | (16'd2 << 9) | 16'd100, 1'b1, "R11");
    check("R11 row from write", int'(refRow), 100);
    check("R11 request dropped", int'(refReq), 0);
    waitReq("R11", 50);

    // R8: clearing enable withdraws the pending request and stays quiet
    writeWord(16'h0007, 1'b0, "R8");
    check("R8 request dropped", int'(refReq), 0);
    repeat (300) @(negedge clk);
    check("R8 still quiet", int'(refReq), 0);
    check("R8 read word", int'(rdData), 7);

    check("R3 all expected requests seen", expQ.size(), 0);
    finishRun();
  end

endmodule